// File: doc/BRIEF.md
# Preemption Countdown Timer

This block lets privileged software win back the processor from a user task. Before control passes to a task, the kernel writes a slice length into the timer. The count then drops by one on each tick. When the count runs out, a single interrupt pulse is raised. The timer keeps the last slice length it was given, so the kernel can restart the same slice for the next task with one strobe and does not have to supply the value again.

Both ways of writing the count are privileged. A write attempted while the processor is in user mode has no effect on the timer. Instead, a one-cycle trap pulse is raised so that the kernel can deal with the offending task. The tick is a one-cycle enable that comes from an external prescaler. The count is visible on an output at all times.

Top module: `slice_timer`

## Requirements
- R1: After reset, `count` is 0, `irq` is 0 and `trap` is 0.
- R2: A `load_stb` with `user_mode` = 0 sets `count` to `load_val` at the next clock edge, and that value becomes the stored slice length.
- R3: With no accepted write, a cycle with `tick` = 1 and a non-zero count lowers `count` by exactly one. A cycle with `tick` = 0 leaves it unchanged.
- R4: `irq` is high for exactly the one cycle in which `count` first shows 0 after a tick moved it from 1 to 0.
- R5: Once at 0, the count stays at 0 through further ticks, and no further `irq` is raised until the timer is written again.
- R6: A privileged load of 0 leaves the timer stopped. `count` stays 0 and no `irq` follows, whatever ticks come.
- R7: A `load_stb` or `rearm` with `user_mode` = 1 (user mode) raises `trap` for one cycle and neither writes `count` nor changes the stored slice length. A tick in the same cycle still decrements.
- R8: When an accepted write and a tick occur in the same cycle, the write wins and the tick is lost.
- R9: A `rearm` with `user_mode` = 0 reloads `count` from the stored slice length at the next edge.
- R10: When `load_stb` and `rearm` are both accepted in one cycle, `load_val` is taken and stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | Current mode bit: 1 = user, 0 = privileged |
| load_stb | input | 1 | Strobe that writes `load_val` as the new count and slice length |
| load_val | input | CNT_W | Slice length to load |
| rearm | input | 1 | Strobe that restarts the count from the stored slice length |
| tick | input | 1 | One-cycle count enable from the prescaler |
| count | output | CNT_W | Current count |
| irq | output | 1 | Expiry interrupt pulse |
| trap | output | 1 | Pulse marking a write rejected in user mode |

## Verification
All three results are registered. A stimulus applied in one cycle therefore shows up on `count`, `irq` and `trap` together, one clock edge later. The driver sets the inputs at the falling edge and pushes the state it predicts for the following rising edge into a queue. The monitor pops one entry and compares it 1 ns after each rising edge, so every comparison lands exactly one edge after its stimulus and clear of that edge. Idle cycles are mixed in between ticks so that holding and decrementing are both checked, along with the lengths of the pulses.

// File: rtl/slice_timer.sv
module slice_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             user_mode,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic             rearm,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             trap
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] slice;
  logic             req;
  logic             wr_ok;
  logic             dec;

  assign req   = load_stb | rearm;
  assign wr_ok = req & ~user_mode;
  assign dec   = tick & ~wr_ok & (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      slice <= '0;
      irq   <= 1'b0;
      trap  <= 1'b0;
    end else begin
      trap <= req & user_mode;
      irq  <= dec & (count == ONE);
      if (wr_ok)
        count <= load_stb ? load_val : slice;
      else if (dec)
        count <= count - ONE;
      if (wr_ok && load_stb)
        slice <= load_val;
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !user_mode) |=> count == $past(load_val)); // R2

  AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && tick && count != '0) |=> count == $past(count) - ONE); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !tick) |=> $stable(count)); // R3

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0 && $past(count) == ONE && $past(tick))); // R4

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5

  AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req && user_mode && !tick) |=> ($stable(count) && trap)); // R7

  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && !$past(req)) |-> 1'b0); // R7

endmodule

// File: tb/test_slice_timer.sv
`timescale 1ns/1ps
module test_slice_timer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         user_mode = 1'b0;
  logic         load_stb = 1'b0;
  logic [W-1:0] load_val = '0;
  logic         rearm = 1'b0;
  logic         tick = 1'b0;
  logic [W-1:0] count;
  logic         irq;
  logic         trap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] cnt;
    logic         irq;
    logic         trap;
    string        tag;
  } exp_t;

  exp_t q[$];
  logic [W-1:0] m_cnt = '0;
  logic [W-1:0] m_slice = '0;

  always #2 clk = ~clk;

  slice_timer #(.CNT_W(W)) i_slice_timer (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .load_stb(load_stb),
    .load_val(load_val), .rearm(rearm), .tick(tick),
    .count(count), .irq(irq), .trap(trap)
  );

  task automatic step(input bit um, input bit ld, input logic [W-1:0] v,
                      input bit ra, input bit tk, input string tag);
    exp_t e;
    bit ok;
    @(negedge clk);
    user_mode = um; load_stb = ld; load_val = v; rearm = ra; tick = tk;
    ok = (ld || ra) && !um;
    e.trap = (ld || ra) && um;
    e.irq = 1'b0;
    if (ok) begin
      if (ld) begin m_cnt = v; m_slice = v; end
      else m_cnt = m_slice;
    end else if (tk && m_cnt != '0) begin
      m_cnt = m_cnt - 1'b1;
      e.irq = (m_cnt == '0);
    end
    e.cnt = m_cnt;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input bit tk, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b0, tk, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (count !== e.cnt || irq !== e.irq || trap !== e.trap) begin
        errors++;
        $display("FAIL %s: count=%0d irq=%0b trap=%0b expected count=%0d irq=%0b trap=%0b",
                 e.tag, count, irq, trap, e.cnt, e.irq, e.trap);
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual not done expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (count !== '0 || irq !== 1'b0 || trap !== 1'b0) begin
      errors++;
      $display("FAIL R1: count=%0d irq=%0b trap=%0b expected 0 0 0", count, irq, trap);
    end
    rst_n = 1'b1;

    step(0, 1, 16'd4, 0, 0, "R2");
    idle(1, 1, "R3");
    idle(2, 0, "R3");
    idle(2, 1, "R3");
    idle(1, 0, "R3");
    idle(1, 1, "R4");
    idle(1, 0, "R4");
    idle(3, 1, "R5");
    step(0, 1, 16'd0, 0, 1, "R6");
    idle(4, 1, "R6");
    step(0, 1, 16'd3, 0, 0, "R2");
    step(1, 1, 16'd9, 0, 0, "R7");
    step(1, 1, 16'd9, 0, 1, "R7");
    step(1, 0, 16'd0, 1, 0, "R7");
    idle(1, 0, "R7");
    step(0, 1, 16'd7, 0, 1, "R8");
    step(0, 0, 16'd0, 1, 1, "R8");
    idle(7, 1, "R9");
    idle(2, 1, "R5");
    step(0, 0, 16'd0, 1, 0, "R9");
    idle(2, 1, "R9");
    step(0, 1, 16'd2, 1, 0, "R10");
    idle(2, 1, "R10");
    step(0, 0, 16'd0, 1, 0, "R10");
    step(0, 1, 16'hFFFF, 0, 0, "R2");
    idle(2, 1, "R3");
    step(1, 1, 16'd1, 1, 0, "R7");
    idle(2, 0, "R7");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule